// File: doc/BRIEF.md
# Feedback DAC Input Router

This block sits between the serial data link that delivers correction samples from a bunch-by-bunch feedback processor and the converter that drives the kicker. Each accepted link word can go to the DAC sample port, to a local sample buffer memory, or to both. A two-bit routing mode chooses the path. A fourth mode plays the buffer back into the DAC as a debug source. An elastic FIFO absorbs the gap between link arrival and DAC playout. Link and DAC share one clock here, so the FIFO covers bursts and the delay before start, not a clock crossing.

Playout is gated by two sticky flags. The first is a start flag, set by a pulse from the acquisition side. The second is a clock-health flag, which drops for good on any missed clock period until the next initialisation. Until both are good, the DAC sees the mid-scale code. A status word reports these flags, the FIFO level flags, a sticky overflow flag and mirrors of the control inputs. The buffer memory sits outside the block, behind a synchronous RAM port with one cycle of read latency.

Top module: `corr_dac_router`

## Requirements
- R1: After reset, or one cycle after `init`, the status word reads clock-lock 1 and FIFO-empty 1, with start, overflow, half and full at 0. `dac_data` holds mid-scale, which is 2^(DATA_W-1).
- R2: The `route` encoding is: 0 sends link data to buffer and DAC, 1 to DAC only, 2 replays the buffer, 3 to buffer only. In modes 0 and 3, each word with `acq_en` and `lnk_valid` high is written to the buffer in the same cycle. Buffer addresses start at 0 and ascend, wrapping at 2^BUF_AW.
- R3: A word enters the FIFO only when `acq_en` and `lnk_valid` are both high and `route` is 0 or 1. In modes 2 and 3 the FIFO is left untouched.
- R4: The start flag (status bit 1) is set one cycle after `start_pulse` and stays set until reset or `init`.
- R5: The clock-lock flag (status bit 0) clears one cycle after `clk_ok` is low and stays clear until reset or `init`.
- R6: `dac_data` is mid-scale in the cycle after any cycle in which start or lock is clear. Otherwise, in modes 0 and 1, a non-empty FIFO gives up one word per cycle, and that word appears on `dac_data` the next cycle, in arrival order. When the FIFO is empty, `dac_data` returns to mid-scale.
- R7: Status bit 3 is FIFO empty, bit 4 is level at least FIFO_DEPTH/2, and bit 5 is level equal to FIFO_DEPTH.
- R8: A push to a full FIFO with no pop in the same cycle is dropped and sets the overflow flag (bit 6). The flag is sticky until reset or `init`. A push to a full FIFO in a cycle that also pops is accepted.
- R9: In mode 2, with start and lock set, the buffer is read at addresses 0, 1, … `replay_last`, then 0 again, one per cycle. Each word reaches `dac_data` two cycles after its read address is presented.
- R10: Status bit 2 (data valid) equals `lnk_valid` of the previous cycle.
- R11: Status bit 7 mirrors `acq_en`, bits 9:8 mirror `route`, and bit 10 mirrors `run_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock for link, FIFO and DAC |
| rst_n | input | 1 | Synchronous active-low reset |
| init | input | 1 | Re-initialise: clear FIFO, pointers and sticky flags, restore lock |
| clk_ok | input | 1 | Low in any cycle where a clock period was missed |
| acq_en | input | 1 | Acquisition enable for link words |
| route | input | 2 | Routing mode (R2) |
| run_mode | input | 1 | Run mode, reported in status only |
| replay_last | input | BUF_AW | Last buffer address played in replay |
| start_pulse | input | 1 | Start request from the acquisition side |
| lnk_valid | input | 1 | Link word valid |
| lnk_data | input | DATA_W | Link correction sample |
| mem_en | output | 1 | Buffer RAM access enable |
| mem_we | output | 1 | Buffer RAM write enable |
| mem_addr | output | BUF_AW | Buffer RAM address |
| mem_wdata | output | DATA_W | Buffer RAM write data |
| mem_rdata | input | DATA_W | Buffer RAM read data, one cycle after the address |
| dac_data | output | DATA_W | Sample code to the DAC |
| status | output | 11 | Status word (R1, R4, R5, R7, R8, R10, R11) |

## Verification
The collision that matters is a push and a pop landing in the same cycle while the FIFO is full. If the design gets it wrong, it either drops a good sample or raises overflow falsely. The bench creates this case by filling the FIFO with start held off, pulsing start during a one-cycle gap in the link, and then streaming one word every cycle. The pop therefore meets a push on a full FIFO. A behavioural queue model checks every cycle that overflow stays clear, that the full flag holds, and that the words reach `dac_data` in order. A second case is the reverse: a push to a full FIFO before start, where the model expects the word to be dropped and overflow to latch.

// File: rtl/corr_dac_router_pkg.sv
// Shared types and status-word bit positions for the DAC input router.
package corr_dac_router_pkg;

    typedef enum logic [1:0] {
        RT_BOTH   = 2'd0,
        RT_DAC    = 2'd1,
        RT_REPLAY = 2'd2,
        RT_BUF    = 2'd3
    } route_e;

    localparam int STAT_W  = 11;
    localparam int ST_LOCK = 0;
    localparam int ST_STRT = 1;
    localparam int ST_DVAL = 2;
    localparam int ST_EMPT = 3;
    localparam int ST_HALF = 4;
    localparam int ST_FULL = 5;
    localparam int ST_OVFL = 6;
    localparam int ST_ACQ  = 7;
    localparam int ST_RTLO = 8;
    localparam int ST_RTHI = 9;
    localparam int ST_RUNM = 10;

endpackage

// File: rtl/cdr_flags.sv
// Sticky start and clock-health flags plus the registered data-valid bit.
// Assumes init is a synchronous one-cycle request; init wins over all other inputs.
module cdr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic clk_ok,
    input  logic start_pulse,
    input  logic lnk_valid,
    output logic lock_q,
    output logic start_q,
    output logic dval_q
);

    // Clock-health flag: drops on a missed period, restored only by init.
    always_ff @(posedge clk) begin
        if (!rst_n || init) lock_q <= 1'b1;
        else if (!clk_ok)   lock_q <= 1'b0;
    end

    // Start flag: set by the start pulse, cleared only by reset or init.
    always_ff @(posedge clk) begin
        if (!rst_n || init)   start_q <= 1'b0;
        else if (start_pulse) start_q <= 1'b1;
    end

    // Data-valid: link activity seen in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) dval_q <= 1'b0;
        else        dval_q <= lnk_valid;
    end

    a_r4_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && !init) |=> start_q);
    a_r4_start_set: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse && !init) |=> start_q);
    a_r5_lock_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_ok && !init) |=> !lock_q);
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && !init) |=> !lock_q);

endmodule

// File: rtl/cdr_fifo.sv
// Elastic sample FIFO with level flags and a sticky overflow flag.
// Assumes DEPTH is a power of two; pop is never requested while empty.
module cdr_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          half,
    output logic          full,
    output logic          ovf
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [DW-1:0] slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          accept, take;

    assign accept = push && (!full || pop);
    assign take   = pop && !empty;
    assign head   = slots[rp];
    assign empty  = (cnt == '0);
    assign full   = (cnt == CW'(DEPTH));
    assign half   = (cnt >= CW'(DEPTH / 2));

    // Storage write for accepted words.
    always_ff @(posedge clk) begin
        if (accept) slots[wp] <= wdata;
    end

    // Pointer and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (accept) wp <= wp + 1'b1;
            if (take)   rp <= rp + 1'b1;
            cnt <= cnt + CW'(accept) - CW'(take);
        end
    end

    // Sticky overflow: a push refused because the FIFO is full.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)            ovf <= 1'b0;
        else if (push && full && !pop) ovf <= 1'b1;
    end

    a_r7_flags_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    a_r7_level_max: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
    a_r8_drop_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (full && ovf));
    a_r8_swap_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && full && !ovf && !clr) |=> (full && !ovf));

endmodule

// File: rtl/cdr_bufport.sv
// Buffer memory port: sequential capture of link words and replay address generation.
// Assumes an external synchronous RAM with one cycle of read latency.
module cdr_bufport
    import corr_dac_router_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  route_e        rt,
    input  logic          acq_en,
    input  logic          lnk_valid,
    input  logic [DW-1:0] lnk_data,
    input  logic          run_en,
    input  logic [AW-1:0] replay_last,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          rd_vld
);

    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          wr_en, rd_en;

    assign wr_en     = acq_en && lnk_valid && (rt == RT_BOTH || rt == RT_BUF);
    assign rd_en     = (rt == RT_REPLAY) && run_en;
    assign mem_we    = wr_en;
    assign mem_en    = wr_en || rd_en;
    assign mem_addr  = rd_en ? rd_ptr : wr_ptr;
    assign mem_wdata = lnk_data;

    // Capture pointer: ascends per stored word, wraps at the buffer size.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) wr_ptr <= '0;
        else if (wr_en)    wr_ptr <= wr_ptr + 1'b1;
    end

    // Replay pointer: restarts at 0 whenever replay is idle, wraps after replay_last.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !rd_en)  rd_ptr <= '0;
        else if (rd_ptr == replay_last) rd_ptr <= '0;
        else                            rd_ptr <= rd_ptr + 1'b1;
    end

    // Read-data valid: marks the cycle in which the RAM returns a replay word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) rd_vld <= 1'b0;
        else               rd_vld <= rd_en;
    end

    a_r9_replay_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |-> (mem_addr == '0));
    a_r9_replay_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !clr && mem_addr == replay_last) |=> (!rd_en || mem_addr == '0));
    a_r2_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

endmodule

// File: rtl/corr_dac_router.sv
// Top of the DAC input router: routes link correction samples to the DAC through an
// elastic FIFO and/or to the sample buffer, or replays the buffer into the DAC.
// Assumes one clock for link and DAC; DAC codes are offset binary (mid-scale = 2^(DATA_W-1)).
module corr_dac_router
    import corr_dac_router_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int BUF_AW     = 10,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              clk_ok,
    input  logic              acq_en,
    input  logic [1:0]        route,
    input  logic              run_mode,
    input  logic [BUF_AW-1:0] replay_last,
    input  logic              start_pulse,
    input  logic              lnk_valid,
    input  logic [DATA_W-1:0] lnk_data,
    output logic              mem_en,
    output logic              mem_we,
    output logic [BUF_AW-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dac_data,
    output logic [STAT_W-1:0] status
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    route_e            rt;
    logic              lock_q, start_q, dval_q, run_en, dac_path;
    logic              push, pop, f_empty, f_half, f_full, f_ovf, rd_vld;
    logic [DATA_W-1:0] f_head;

    assign rt       = route_e'(route);
    assign run_en   = start_q && lock_q;
    assign dac_path = (rt == RT_BOTH) || (rt == RT_DAC);
    assign push     = acq_en && lnk_valid && dac_path;
    assign pop      = run_en && dac_path && !f_empty;

    cdr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .clk_ok     (clk_ok),
        .start_pulse(start_pulse),
        .lnk_valid  (lnk_valid),
        .lock_q     (lock_q),
        .start_q    (start_q),
        .dval_q     (dval_q)
    );

    cdr_fifo #(.DW(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (init),
        .push (push),
        .pop  (pop),
        .wdata(lnk_data),
        .head (f_head),
        .empty(f_empty),
        .half (f_half),
        .full (f_full),
        .ovf  (f_ovf)
    );

    cdr_bufport #(.DW(DATA_W), .AW(BUF_AW)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (init),
        .rt         (rt),
        .acq_en     (acq_en),
        .lnk_valid  (lnk_valid),
        .lnk_data   (lnk_data),
        .run_en     (run_en),
        .replay_last(replay_last),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .rd_vld     (rd_vld)
    );

    // DAC output register: FIFO word, replay word, or mid-scale when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || init)                         dac_data <= MID;
        else if (pop)                               dac_data <= f_head;
        else if (rt == RT_REPLAY && run_en && rd_vld) dac_data <= mem_rdata;
        else                                        dac_data <= MID;
    end

    // Status word assembly.
    always_comb begin
        status           = '0;
        status[ST_LOCK]  = lock_q;
        status[ST_STRT]  = start_q;
        status[ST_DVAL]  = dval_q;
        status[ST_EMPT]  = f_empty;
        status[ST_HALF]  = f_half;
        status[ST_FULL]  = f_full;
        status[ST_OVFL]  = f_ovf;
        status[ST_ACQ]   = acq_en;
        status[ST_RTLO]  = route[0];
        status[ST_RTHI]  = route[1];
        status[ST_RUNM]  = run_mode;
    end

    a_r6_mid_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (dac_data == MID));
    a_r3_no_push_off_path: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_path && f_empty && !init) |=> f_empty);
    a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (status[ST_EMPT] && status[ST_LOCK] && !status[ST_STRT] && !status[ST_OVFL]));

endmodule

// File: tb/corr_dac_router_test.sv
module corr_dac_router_test;

    localparam int PERIOD = 10;
    localparam int DW     = 12;
    localparam int AW     = 5;
    localparam int NB     = 1 << AW;
    localparam int DEPTH  = 8;
    localparam int MID    = 1 << (DW - 1);

    logic          clk = 1'b0;
    logic          rst_n, init, clk_ok, acq_en, run_mode, start_pulse, lnk_valid;
    logic [1:0]    route;
    logic [AW-1:0] replay_last;
    logic [DW-1:0] lnk_data;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata, dac_data;
    logic [10:0]   status;

    int n_tests = 0;
    int n_fail  = 0;

    always #(PERIOD / 2) clk = ~clk;

    corr_dac_router #(.DATA_W(DW), .BUF_AW(AW), .FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .init(init), .clk_ok(clk_ok), .acq_en(acq_en),
        .route(route), .run_mode(run_mode), .replay_last(replay_last),
        .start_pulse(start_pulse), .lnk_valid(lnk_valid), .lnk_data(lnk_data),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dac_data(dac_data), .status(status)
    );

    // Synchronous RAM with one cycle of read latency.
    logic [DW-1:0] ram [NB];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NB; i++) ram[i] <= '0;
        end else if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
        end
        if (mem_en) mem_rdata <= ram[mem_addr];
    end

    // Behavioural reference model state.
    int q[$];
    int mref[NB];
    bit m_lock, m_start, m_dv, m_ovf, m_rpv;
    int m_dac, m_rdd, m_wptr, m_rp;
    bit checking = 1'b0;

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit m_run();
        return m_start && m_lock;
    endfunction

    // Compare every output with the model before the coming edge.
    task automatic compare();
        bit bufw, rd;
        int exp_addr;
        bufw = acq_en && lnk_valid && (route == 0 || route == 3);
        rd   = (route == 2) && m_run();
        exp_addr = rd ? m_rp : m_wptr;
        chk(route == 2 ? "R9" : "R6", "dac_data", int'(dac_data), m_dac);
        chk("R2", "mem_we", int'(mem_we), int'(bufw));
        chk("R2", "mem_en", int'(mem_en), int'(bufw || rd));
        if (bufw || rd) chk(rd ? "R9" : "R2", "mem_addr", int'(mem_addr), exp_addr);
        if (bufw) chk("R2", "mem_wdata", int'(mem_wdata), int'(lnk_data));
        chk("R5",  "lock",   int'(status[0]), int'(m_lock));
        chk("R4",  "start",  int'(status[1]), int'(m_start));
        chk("R10", "dvalid", int'(status[2]), int'(m_dv));
        chk("R7",  "empty",  int'(status[3]), int'(q.size() == 0));
        chk("R7",  "half",   int'(status[4]), int'(q.size() >= DEPTH / 2));
        chk("R7",  "full",   int'(status[5]), int'(q.size() == DEPTH));
        chk("R8",  "ovf",    int'(status[6]), int'(m_ovf));
        chk("R11", "mirror", int'(status[10:7]), int'({run_mode, route, acq_en}));
    endtask

    // Advance the model by one clock edge using the inputs held across it.
    task automatic step();
        bit dpath, bufw, push, rd, pop, run;
        int nd, old_size;
        if (!rst_n) begin
            q.delete();
            m_lock = 1; m_start = 0; m_dv = 0; m_ovf = 0; m_rpv = 0;
            m_dac = MID; m_rdd = 0; m_wptr = 0; m_rp = 0;
            for (int i = 0; i < NB; i++) mref[i] = 0;
            return;
        end
        run   = m_run();
        dpath = (route == 0 || route == 1);
        bufw  = acq_en && lnk_valid && (route == 0 || route == 3);
        push  = acq_en && lnk_valid && dpath;
        rd    = (route == 2) && run;
        pop   = run && dpath && q.size() > 0;
        nd = init ? MID : pop ? q[0] : (route == 2 && run && m_rpv) ? m_rdd : MID;
        if (rd) m_rdd = mref[m_rp];
        if (bufw) mref[m_wptr] = int'(lnk_data);
        if (init) begin
            q.delete();
            m_ovf = 0;
        end else begin
            old_size = q.size();
            if (pop) void'(q.pop_front());
            if (push) begin
                if (old_size < DEPTH || pop) q.push_back(int'(lnk_data));
                else m_ovf = 1;
            end
        end
        m_dac  = nd;
        m_rp   = (init || !rd) ? 0 : (m_rp == int'(replay_last) ? 0 : m_rp + 1);
        m_rpv  = init ? 0 : rd;
        m_wptr = init ? 0 : (bufw ? (m_wptr + 1) % NB : m_wptr);
        m_lock = init ? 1 : (clk_ok ? m_lock : 0);
        m_start = init ? 0 : (start_pulse ? 1 : m_start);
        m_dv   = lnk_valid;
    endtask

    task automatic tick();
        #1;
        if (checking) compare();
        @(posedge clk);
        step();
        @(negedge clk);
    endtask

    task automatic send(int n);
        for (int i = 0; i < n; i++) begin
            lnk_valid = 1'b1;
            lnk_data  = DW'($urandom);
            tick();
        end
        lnk_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 0; init = 0; clk_ok = 1; acq_en = 0; route = 2'd1; run_mode = 0;
        replay_last = '0; start_pulse = 0; lnk_valid = 0; lnk_data = '0;
        void'($urandom(7));
        @(negedge clk);
        idle(3);
        rst_n = 1;
        route = 2'd0;
        #1;
        // R1: reset state of the status word and DAC code
        chk("R1", "status after reset", int'(status), 'h009);
        chk("R1", "dac after reset", int'(dac_data), MID);
        checking = 1'b1;

        // DAC-only, words queued before start
        route = 2'd1; acq_en = 1;
        send(5);
        idle(3);
        #1;
        chk("R6", "dac idle before start", int'(dac_data), MID);
        // Overfill without start: words beyond depth are dropped
        send(6);
        idle(1);
        #1;
        chk("R8", "ovf after push to full", int'(status[6]), 1);
        chk("R7", "full after overfill", int'(status[5]), 1);
        start_pulse = 1; tick(); start_pulse = 0;
        #1;
        chk("R4", "start set after pulse", int'(status[1]), 1);
        idle(12);

        // Same-cycle push and pop on a full FIFO
        init = 1; tick(); init = 0;
        #1;
        chk("R1", "status after init", int'(status[6:0]), 'h09);
        send(DEPTH);
        start_pulse = 1; tick(); start_pulse = 0;
        send(10);
        #1;
        chk("R8", "no ovf on push with pop at full", int'(status[6]), 0);
        idle(12);

        // Both paths, then buffer only
        route = 2'd0; send(20); idle(10);
        route = 2'd3; send(10); idle(2);
        #1;
        chk("R3", "fifo untouched in buffer-only", int'(status[3]), 1);

        // Replay, then a clock miss
        route = 2'd2; replay_last = 5'd5; run_mode = 1;
        idle(20);
        replay_last = 5'd27; idle(40);
        clk_ok = 0; tick(); clk_ok = 1;
        idle(2);
        #1;
        chk("R5", "lock cleared after miss", int'(status[0]), 0);
        chk("R6", "dac mid after lock loss", int'(dac_data), MID);
        init = 1; tick(); init = 0;
        #1;
        chk("R5", "lock restored by init", int'(status[0]), 1);

        // Random traffic
        for (int c = 0; c < 3000; c++) begin
            lnk_valid   = ($urandom % 4) != 0;
            lnk_data    = DW'($urandom);
            acq_en      = ($urandom % 8) != 0;
            start_pulse = ($urandom % 60) == 0;
            init        = ($urandom % 250) == 0;
            clk_ok      = ($urandom % 400) != 0;
            run_mode    = $urandom % 2;
            if ($urandom % 40 == 0) route = 2'($urandom);
            if ($urandom % 100 == 0) replay_last = AW'($urandom);
            tick();
        end
        init = 0; clk_ok = 1; start_pulse = 0; lnk_valid = 0;
        idle(4);
        finish_run();
    end

endmodule